// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Front End

This block turns six asynchronous external interrupt pins into sticky request flags for a CPU interrupt controller. Each pin first passes through a two-stage synchroniser. An edge detector then compares the newest synchronised sample with the previous one. Each channel is set to one of two modes:

- **Single edge:** a per-channel polarity bit picks the falling edge (0) or the rising edge (1).
- **Both edges:** any change of the pin is an event. Software is expected to leave the polarity bit at 0 in this mode, and the detector ignores that bit.

The block holds eight request slots:

- Slots 0 to 3 belong to external channels 0 to 3.
- Slot 4 is shared between serial port 3 and external channel 4.
- Slot 5 is shared between serial port 4 and external channel 5.
- Slot 6 is shared between a timer B3 request and a UART0 bus-collision request.
- Slot 7 is shared between a timer B4 request and a UART1 bus-collision request.

Select bits choose which source owns each shared slot. A source that is not selected cannot set the slot. An edge seen while a channel was deselected is dropped, not stored.

Software reaches four byte-wide registers through a simple write/read bus:

| Address | Register | Contents |
|---|---|---|
| 0 | Edge/route select | Bits 5:0 set both-edge mode for channels 0 to 5. Bit 6 gives slot 4 to external channel 4. Bit 7 gives slot 5 to external channel 5. |
| 1 | Alternate select | Bit 6 gives slot 6 to UART0 bus collision. Bit 7 gives slot 7 to UART1 bus collision. Bits 5:0 are not stored. |
| 2 | Polarity | Bits 5:0, where 1 means rising edge. |
| 3 | Request flags | Bit n is slot n. |

Writing 0 to a flag bit clears that flag, and writing 1 leaves it as it is. Vector fetch and priority resolution are done elsewhere.

Top module: `xint_front`

## Requirements
- R1: After reset, registers 0, 1 and 2 read 00h and all request flags (register 3 and `irq_req_o`) are 0.
- R2: With mode bit 0 and polarity 0, a falling edge on an external pin sets its flag, and a rising edge does not.
- R3: With mode bit 0 and polarity 1, a rising edge sets the flag, and a falling edge does not.
- R4: With mode bit 1 in register 0 and polarity 0, both the rising and the falling edge set the flag.
- R5: A pin change made between clock edges sets its flag at the third following rising clock edge, and not at the second.
- R6: Register 0 bit 6 gives slot 4 to serial port 3 when 0 and to external channel 4 when 1. Bit 7 does the same for slot 5, choosing between serial port 4 and external channel 5.
- R7: Register 1 bit 6 gives slot 6 to the timer B3 request when 0 and to the UART0 bus-collision request when 1. Bit 7 does the same for slot 7, choosing between timer B4 and UART1 bus collision. Bits 5:0 of register 1 read 0.
- R8: Writing to register 3 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R9: If a set event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: A source that is not selected for a shared slot never sets it. An edge that occurred while the source was deselected does not set the flag after the source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 6 | Asynchronous external interrupt pins 0 to 5 |
| ser3_irq_i | input | 1 | Serial port 3 request pulse (synchronous) |
| ser4_irq_i | input | 1 | Serial port 4 request pulse (synchronous) |
| tmr3_irq_i | input | 1 | Timer B3 request pulse (synchronous) |
| tmr4_irq_i | input | 1 | Timer B4 request pulse (synchronous) |
| bcol0_irq_i | input | 1 | UART0 bus-collision request pulse |
| bcol1_irq_i | input | 1 | UART1 bus-collision request pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| irq_req_o | output | 8 | Request flags, bit n = slot n |

## Verification
A source's set event and a software write of 0 to the same flag can land on the same clock edge. The bench provokes this by pulsing the UART0 bus-collision source in the same cycle as a write of 00h to register 3, while another flag is already set. It judges the result by expecting the pulsed flag to remain set and the other flag to be cleared. The same path is also checked in the other direction, with a clear and no set, and with a write of 1s that must leave the flags unchanged.

// File: rtl/xint_pkg.sv
// Package: shared sizes and register addresses for the external interrupt front end.
package xint_pkg;
    localparam int NUM_EXT   = 6;   // external pins
    localparam int NUM_SLOT  = 8;   // request slots
    localparam int REG_W     = 8;   // register width
    localparam int ADDR_W    = 2;   // register address width
    localparam int SYNC_DEPTH = 2;  // synchroniser stages

    localparam logic [ADDR_W-1:0] ADDR_EDGE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ALT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_POL  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_REQ  = 2'd3;

    // bit positions inside the edge/route register
    localparam int RT_SLOT4 = 6;
    localparam int RT_SLOT5 = 7;
endpackage

// File: rtl/xint_edge_chan.sv
// Module: one external channel. Synchronises an asynchronous pin through
// SYNC_STAGES flops, keeps the previous synchronised sample and emits a
// one-cycle event on the qualifying edge. Assumes SYNC_STAGES >= 2 and that
// the pin is low while reset is applied (all stages reset to 0).
module xint_edge_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic both_i,   // 1: every change is an event
    input  logic pol_i,    // single-edge: 1 rising, 0 falling
    output logic evt_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   samp;

    assign samp = chain_q[SYNC_STAGES-1];

    // Shift the pin through the synchroniser and remember the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
            prev_q  <= samp;
        end
    end

    // Classify the change between previous and current sample.
    always_comb begin
        if (both_i)
            evt_o = samp ^ prev_q;
        else if (pol_i)
            evt_o = samp & ~prev_q;
        else
            evt_o = ~samp & prev_q;
    end

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!both_i && !pol_i && evt_o) |-> !samp);   // R2
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!both_i && pol_i && evt_o) |-> samp);     // R3
    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (samp != $past(samp)));          // R4
endmodule

// File: rtl/xint_cfg_regs.sv
// Module: holds the edge/route select, alternate select and polarity
// registers. Only the stored bits exist; unused bits are not kept.
// Assumes a write strobe qualified by address, applied at the clock edge.
module xint_cfg_regs
    import xint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  edge_cfg_o,
    output logic [1:0]        alt_cfg_o,
    output logic [NUM_EXT-1:0] pol_o
);
    // Capture software writes into the select and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cfg_o <= '0;
            alt_cfg_o  <= '0;
            pol_o      <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADDR_EDGE: edge_cfg_o <= wdata_i;
                ADDR_ALT:  alt_cfg_o  <= wdata_i[REG_W-1:REG_W-2];
                ADDR_POL:  pol_o      <= wdata_i[NUM_EXT-1:0];
                default:   ;
            endcase
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(edge_cfg_o) && $stable(alt_cfg_o) && $stable(pol_o))); // R1
endmodule

// File: rtl/xint_slot_route.sv
// Module: steers channel events and on-chip request pulses onto the eight
// request slots according to the select bits. A deselected source has no
// path to its slot. Assumes all inputs are synchronous single-cycle pulses.
module xint_slot_route
    import xint_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXT-1:0]  ext_evt_i,
    input  logic                route4_ext_i,
    input  logic                route5_ext_i,
    input  logic                alt6_i,
    input  logic                alt7_i,
    input  logic                ser3_i,
    input  logic                ser4_i,
    input  logic                tmr3_i,
    input  logic                tmr4_i,
    input  logic                bcol0_i,
    input  logic                bcol1_i,
    output logic [NUM_SLOT-1:0] slot_set_o
);
    // Pick the owner of each slot.
    always_comb begin
        slot_set_o[3:0] = ext_evt_i[3:0];
        slot_set_o[4]   = route4_ext_i ? ext_evt_i[4] : ser3_i;
        slot_set_o[5]   = route5_ext_i ? ext_evt_i[5] : ser4_i;
        slot_set_o[6]   = alt6_i ? bcol0_i : tmr3_i;
        slot_set_o[7]   = alt7_i ? bcol1_i : tmr4_i;
    end

    AST_SLOT4_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!route4_ext_i && !ser3_i) |-> !slot_set_o[4]);        // R10
    AST_SLOT4_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (route4_ext_i && ext_evt_i[4]) |-> slot_set_o[4]);     // R6
    AST_SLOT6_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (alt6_i && !bcol0_i) |-> !slot_set_o[6]);              // R7
endmodule

// File: rtl/xint_req_flags.sv
// Module: sticky request flags. A set pulse raises a flag; a clear mask
// lowers it; set wins when both hit the same flag in one cycle.
module xint_req_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    // Update flags: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else
            q_o <= set_i | (q_o & ~clr_i);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));           // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o));                 // R8
endmodule

// File: rtl/xint_front.sv
// Module: top of the external interrupt front end. Six synchronised edge
// channels, slot routing, sticky flags and a four-register access bus.
// Assumes pins are held low during reset and on-chip sources are
// single-cycle synchronous pulses. Read data is combinational from address.
module xint_front
    import xint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        ext_pin_i,
    input  logic              ser3_irq_i,
    input  logic              ser4_irq_i,
    input  logic              tmr3_irq_i,
    input  logic              tmr4_irq_i,
    input  logic              bcol0_irq_i,
    input  logic              bcol1_irq_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic [7:0]        irq_req_o
);
    logic [REG_W-1:0]    edge_cfg;
    logic [1:0]          alt_cfg;
    logic [NUM_EXT-1:0]  pol;
    logic [NUM_EXT-1:0]  ext_evt;
    logic [NUM_SLOT-1:0] slot_set;
    logic [NUM_SLOT-1:0] slot_clr;

    xint_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .edge_cfg_o (edge_cfg),
        .alt_cfg_o  (alt_cfg),
        .pol_o      (pol)
    );

    for (genvar c = 0; c < NUM_EXT; c++) begin : g_chan
        xint_edge_chan #(.SYNC_STAGES(SYNC_DEPTH)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_pin_i[c]),
            .both_i (edge_cfg[c]),
            .pol_i  (pol[c]),
            .evt_o  (ext_evt[c])
        );
    end

    xint_slot_route u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_evt_i    (ext_evt),
        .route4_ext_i (edge_cfg[RT_SLOT4]),
        .route5_ext_i (edge_cfg[RT_SLOT5]),
        .alt6_i       (alt_cfg[0]),
        .alt7_i       (alt_cfg[1]),
        .ser3_i       (ser3_irq_i),
        .ser4_i       (ser4_irq_i),
        .tmr3_i       (tmr3_irq_i),
        .tmr4_i       (tmr4_irq_i),
        .bcol0_i      (bcol0_irq_i),
        .bcol1_i      (bcol1_irq_i),
        .slot_set_o   (slot_set)
    );

    // Software clear mask: a written 0 clears the matching flag.
    assign slot_clr = (reg_we_i && reg_addr_i == ADDR_REQ) ? ~reg_wdata_i : '0;

    xint_req_flags #(.N(NUM_SLOT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (slot_set),
        .clr_i (slot_clr),
        .q_o   (irq_req_o)
    );

    // Register read multiplexer.
    always_comb begin
        case (reg_addr_i)
            ADDR_EDGE: reg_rdata_o = edge_cfg;
            ADDR_ALT:  reg_rdata_o = {alt_cfg, {(REG_W-2){1'b0}}};
            ADDR_POL:  reg_rdata_o = {{(REG_W-NUM_EXT){1'b0}}, pol};
            default:   reg_rdata_o = irq_req_o;
        endcase
    end

    AST_ALT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_ALT) |-> (reg_rdata_o[REG_W-3:0] == '0)); // R7
endmodule

// File: tb/xint_front_tb_top.sv
module xint_front_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ext_pin = '0;
    logic       ser3 = 0, ser4 = 0, tmr3 = 0, tmr4 = 0, bcol0 = 0, bcol1 = 0;
    logic       we = 0;
    logic [1:0] addr = 2'd3;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit       use_rd;
        logic [7:0] exp;
        string    tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    xint_front dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin),
        .ser3_irq_i(ser3), .ser4_irq_i(ser4), .tmr3_irq_i(tmr3), .tmr4_irq_i(tmr4),
        .bcol0_irq_i(bcol0), .bcol1_irq_i(bcol1),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_req_o(req)
    );

    // Monitor: pops expected items at the falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.use_rd ? rdata : req;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_flags(input logic [7:0] e, input string tag);
        item_t it;
        it.use_rd = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        addr = a;
        it.use_rd = 1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1; addr = a; wdata = d;
        step(1);
        we = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1;
        step(1);
        // R1 reset state
        exp_flags(8'h00, "R1 flags");
        exp_read(2'd0, 8'h00, "R1 reg0");
        exp_read(2'd1, 8'h00, "R1 reg1");
        exp_read(2'd2, 8'h00, "R1 reg2");
        exp_read(2'd3, 8'h00, "R1 reg3");

        // R2 falling edge, rising ignored
        ext_pin[0] = 1; step(4);
        exp_flags(8'h00, "R2 rise ignored");
        ext_pin[0] = 0; step(2);
        exp_flags(8'h00, "R5 not at 2nd edge");
        step(1);
        exp_flags(8'h01, "R5/R2 set at 3rd edge");
        step(1);
        // R8 write 1 keeps, write 0 clears
        wr(2'd3, 8'hFF);
        exp_flags(8'h01, "R8 write ones keeps");
        step(1);
        wr(2'd3, 8'hFE);
        exp_flags(8'h00, "R8 write zero clears");
        step(1);

        // R3 rising polarity
        wr(2'd2, 8'h02);
        exp_read(2'd2, 8'h02, "R3 polarity readback");
        ext_pin[1] = 1; step(3);
        exp_flags(8'h02, "R3 rise sets");
        step(1);
        wr(2'd3, 8'h00);
        ext_pin[1] = 0; step(4);
        exp_flags(8'h00, "R3 fall ignored");
        step(1);

        // R4 both edges
        wr(2'd0, 8'h04);
        ext_pin[2] = 1; step(3);
        exp_flags(8'h04, "R4 rise sets");
        step(1);
        wr(2'd3, 8'h00);
        ext_pin[2] = 0; step(3);
        exp_flags(8'h04, "R4 fall sets");
        step(1);
        wr(2'd3, 8'h00);

        // R6/R10 slot 4
        ser3 = 1; step(1); ser3 = 0;
        exp_flags(8'h10, "R6 serial3 owns slot4");
        step(1);
        wr(2'd3, 8'h00);
        ext_pin[4] = 1; step(2); ext_pin[4] = 0; step(4);
        exp_flags(8'h00, "R10 ext4 deselected");
        step(1);
        wr(2'd0, 8'h44);
        step(2);
        exp_flags(8'h00, "R10 edge not remembered");
        step(1);
        ser3 = 1; step(1); ser3 = 0;
        exp_flags(8'h00, "R10 serial3 deselected");
        step(1);
        ext_pin[4] = 1; step(2); ext_pin[4] = 0; step(3);
        exp_flags(8'h10, "R6 ext4 owns slot4");
        step(1);
        wr(2'd3, 8'h00);
        // slot 5
        wr(2'd0, 8'hC4);
        ser4 = 1; step(1); ser4 = 0;
        exp_flags(8'h00, "R10 serial4 deselected");
        step(1);
        ext_pin[5] = 1; step(2); ext_pin[5] = 0; step(3);
        exp_flags(8'h20, "R6 ext5 owns slot5");
        step(1);
        wr(2'd3, 8'h00);

        // R7 timer / bus-collision slots
        tmr3 = 1; step(1); tmr3 = 0;
        exp_flags(8'h40, "R7 timer3 owns slot6");
        step(1);
        wr(2'd3, 8'h00);
        bcol0 = 1; step(1); bcol0 = 0;
        exp_flags(8'h00, "R7 bcol0 deselected");
        step(1);
        wr(2'd1, 8'hFF);
        exp_read(2'd1, 8'hC0, "R7 reg1 low bits zero");
        bcol1 = 1; step(1); bcol1 = 0;
        exp_flags(8'h80, "R7 bcol1 owns slot7");
        step(1);
        tmr4 = 1; step(1); tmr4 = 0;
        exp_flags(8'h80, "R7 timer4 deselected");
        step(1);

        // R9 set wins over clear in same cycle
        bcol0 = 1; we = 1; addr = 2'd3; wdata = 8'h00;
        step(1);
        bcol0 = 0; we = 0;
        exp_flags(8'h40, "R9 set wins, other cleared");
        step(2);

        done = 1;
        summary();
        $finish;
    end
endmodule